// File: doc/BRIEF.md
# Chipset Memory Address Decoder

This block sorts each memory request by address and sends it to system DRAM, to the graphics port, to the processor bus as an interrupt message, or to the default hub-interface path. Each request brings its address, the agent that issued it (processor bus, hub interface or graphics port), a read/write flag, a processor-side qualifier for SMM accesses, and write data. The programmed configuration comes in as plain inputs: top of memory, an aperture base and size, two base/limit memory windows, and the two SMRAM enables. All window values are given in 1 MB units.

Two fixed regions get special handling. Non-processor writes into the 1 MB interrupt window at 0xFEE0_0000 become interrupt messages on the processor bus, and the block completes these writes itself. The 128 KB high-SMM alias at 0xFEDA_0000 maps down onto the legacy area at 0x000A_0000, but only for qualified processor accesses when both SMRAM enables are set. Agents other than the processor that touch the alias get a special termination: a read is answered from address 0, and a write is dropped. Decode is combinational and goes through one register stage, so every result appears one cycle after its request.

Top module: `mem_addr_router`

## Requirements
- R1: A write from the hub (source 1 or 3) or graphics (source 2) agent with an address in 0xFEE0_0000..0xFEEF_FFFF leaves with target code 2 (processor bus), out_intr_msg set, and its address and write data unchanged.
- R2: That same write also raises out_self_complete. Every other access in that window (a read, or any processor access with source 0) goes to target 3 (hub) and never to target 0 (DRAM).
- R3: A processor access (source 0) in 0xFEDA_0000..0xFEDB_FFFF that has req_smm_qual, cfg_smram_en and cfg_hsmram_en all set goes to target 0 at address minus 0xFED0_0000.
- R4: If any one of those three conditions is missing, the processor access is not remapped. It is decoded by the lower-priority rules with its address unchanged.
- R5: A non-processor read in 0xFEDA_0000..0xFEDB_FFFF goes to target 0 at address 0 with out_read_zero set, whatever the enables are.
- R6: A non-processor write in that range goes to target 4 (discard) with out_write_drop set.
- R7: An address whose MB index lies in [ap_base, ap_base+ap_size) goes to target 1 (graphics) unchanged. The aperture is off when its size is 0 or when its base is below top of memory.
- R8: An address inside either inclusive base/limit window goes to target 1, but only at or above top of memory. A window whose limit is below its base is off.
- R9: Priority from highest to lowest: interrupt window, high-SMM alias, aperture and windows, DRAM.
- R10: Any other address below top of memory goes to target 0 unchanged. All remaining addresses go to target 3.
- R11: Every output is registered. A result appears one cycle after its request, out_valid follows req_valid with that same delay, and reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | Request address |
| req_src | input | 2 | 0 processor, 1 hub, 2 graphics, 3 hub |
| req_write | input | 1 | 1 write, 0 read |
| req_smm_qual | input | 1 | Processor access qualifies for SMM |
| req_wdata | input | DW | Write data |
| cfg_smram_en | input | 1 | SMRAM enabled |
| cfg_hsmram_en | input | 1 | High-SMM alias enabled |
| cfg_tom | input | AW-20 | Top of memory, MB |
| cfg_ap_base | input | AW-20 | Aperture base, MB |
| cfg_ap_size | input | AW-20 | Aperture size, MB |
| cfg_mem_base | input | AW-20 | Memory window base, MB |
| cfg_mem_limit | input | AW-20 | Memory window limit, MB inclusive |
| cfg_pmem_base | input | AW-20 | Prefetchable window base, MB |
| cfg_pmem_limit | input | AW-20 | Prefetchable window limit, MB inclusive |
| out_valid | output | 1 | Registered request present |
| out_target | output | 3 | 0 DRAM, 1 graphics, 2 processor bus, 3 hub, 4 discard |
| out_addr | output | AW | Translated address |
| out_wdata | output | DW | Registered write data |
| out_intr_msg | output | 1 | Interrupt message |
| out_self_complete | output | 1 | Decoder completes the transaction |
| out_read_zero | output | 1 | Read answered from address 0 |
| out_write_drop | output | 1 | Write discarded |

## Verification
The bench builds the block with AW = 32, which gives a 12-bit MB index and lets the test reach the fixed regions near 4 GB. It uses DW = 16 so that it can see the write data path separately from the address width. With these sizes the test can drive the first and last byte of each fixed region and each programmed window, cover every combination of the three SMM conditions, and move top of memory across windows and the aperture to show that they get clipped.

// File: rtl/mem_addr_router.sv
module mem_addr_router #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_src,
  input  logic          req_write,
  input  logic          req_smm_qual,
  input  logic [DW-1:0] req_wdata,
  input  logic          cfg_smram_en,
  input  logic          cfg_hsmram_en,
  input  logic [AW-21:0] cfg_tom,
  input  logic [AW-21:0] cfg_ap_base,
  input  logic [AW-21:0] cfg_ap_size,
  input  logic [AW-21:0] cfg_mem_base,
  input  logic [AW-21:0] cfg_mem_limit,
  input  logic [AW-21:0] cfg_pmem_base,
  input  logic [AW-21:0] cfg_pmem_limit,
  output logic          out_valid,
  output logic [2:0]    out_target,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_wdata,
  output logic          out_intr_msg,
  output logic          out_self_complete,
  output logic          out_read_zero,
  output logic          out_write_drop
);
  localparam int MBW = AW - 20;
  localparam logic [AW-1:0] INTR_LO = AW'(32'hFEE0_0000);
  localparam logic [AW-1:0] INTR_HI = AW'(32'hFEEF_FFFF);
  localparam logic [AW-1:0] HSMM_LO = AW'(32'hFEDA_0000);
  localparam logic [AW-1:0] HSMM_HI = AW'(32'hFEDB_FFFF);
  localparam logic [AW-1:0] HSMM_OFS = AW'(32'hFED0_0000);
  localparam logic [2:0] T_DRAM = 3'd0, T_GFX = 3'd1, T_CPU = 3'd2, T_HUB = 3'd3, T_NONE = 3'd4;

  logic [MBW-1:0] mb;
  logic           from_cpu, in_intr, in_hsmm, hsmm_remap;
  logic [MBW:0]   ap_end;
  logic           ap_hit, m_hit, pm_hit, below_tom;

  assign mb         = req_addr[AW-1:20];
  assign from_cpu   = (req_src == 2'd0);
  assign in_intr    = (req_addr >= INTR_LO) && (req_addr <= INTR_HI);
  assign in_hsmm    = (req_addr >= HSMM_LO) && (req_addr <= HSMM_HI);
  assign hsmm_remap = in_hsmm && from_cpu && req_smm_qual && cfg_smram_en && cfg_hsmram_en;
  assign below_tom  = (mb < cfg_tom);

  assign ap_end = {1'b0, cfg_ap_base} + {1'b0, cfg_ap_size};
  assign ap_hit = (cfg_ap_size != '0) && (cfg_ap_base >= cfg_tom) &&
                  (mb >= cfg_ap_base) && ({1'b0, mb} < ap_end);
  assign m_hit  = (cfg_mem_limit >= cfg_mem_base) && !below_tom &&
                  (mb >= cfg_mem_base) && (mb <= cfg_mem_limit);
  assign pm_hit = (cfg_pmem_limit >= cfg_pmem_base) && !below_tom &&
                  (mb >= cfg_pmem_base) && (mb <= cfg_pmem_limit);

  logic [2:0]    d_target;
  logic [AW-1:0] d_addr;
  logic          d_intr, d_selfc, d_rzero, d_wdrop;

  always_comb begin
    d_target = T_HUB;
    d_addr   = req_addr;
    d_intr   = 1'b0;
    d_selfc  = 1'b0;
    d_rzero  = 1'b0;
    d_wdrop  = 1'b0;
    if (in_intr) begin
      if (!from_cpu && req_write) begin
        d_target = T_CPU;
        d_intr   = 1'b1;
        d_selfc  = 1'b1;
      end
    end else if (in_hsmm && !from_cpu) begin
      if (req_write) begin
        d_target = T_NONE;
        d_wdrop  = 1'b1;
      end else begin
        d_target = T_DRAM;
        d_addr   = '0;
        d_rzero  = 1'b1;
      end
    end else if (hsmm_remap) begin
      d_target = T_DRAM;
      d_addr   = req_addr - HSMM_OFS;
    end else if (ap_hit || m_hit || pm_hit) begin
      d_target = T_GFX;
    end else if (below_tom) begin
      d_target = T_DRAM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid         <= 1'b0;
      out_target        <= T_DRAM;
      out_addr          <= '0;
      out_wdata         <= '0;
      out_intr_msg      <= 1'b0;
      out_self_complete <= 1'b0;
      out_read_zero     <= 1'b0;
      out_write_drop    <= 1'b0;
    end else begin
      out_valid         <= req_valid;
      out_target        <= d_target;
      out_addr          <= d_addr;
      out_wdata         <= req_wdata;
      out_intr_msg      <= d_intr;
      out_self_complete <= d_selfc;
      out_read_zero     <= d_rzero;
      out_write_drop    <= d_wdrop;
    end
  end
endmodule

module mem_addr_router_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_src,
  input logic          req_write,
  input logic          req_smm_qual,
  input logic          cfg_smram_en,
  input logic          cfg_hsmram_en,
  input logic          out_valid,
  input logic [2:0]    out_target,
  input logic [AW-1:0] out_addr,
  input logic          out_intr_msg,
  input logic          out_self_complete,
  input logic          out_read_zero,
  input logic          out_write_drop
);
  logic c_intr, c_hsmm;
  assign c_intr = (req_addr[AW-1:20] == (AW-20)'(12'hFEE));
  assign c_hsmm = (req_addr[AW-1:17] == (AW-17)'(15'h7F6D));

  p_intr_not_dram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_intr |=> out_target != 3'd0);

  p_intr_msg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_intr && req_write && req_src != 2'd0) |=>
      (out_target == 3'd2 && out_intr_msg && out_self_complete));

  p_smm_remap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hsmm && req_src == 2'd0 && req_smm_qual && cfg_smram_en && cfg_hsmram_en) |=>
      (out_target == 3'd0 && out_addr[AW-1:20] == '0 && out_addr[19:0] == $past(req_addr[19:0]) + 20'h0_0000));

  p_smm_rd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hsmm && req_src != 2'd0 && !req_write) |=>
      (out_read_zero && out_addr == '0 && out_target == 3'd0));

  p_smm_wr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hsmm && req_src != 2'd0 && req_write) |=> (out_write_drop && out_target == 3'd4));

  p_valid_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(req_valid));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_intr_msg, out_read_zero, out_write_drop}));
endmodule

bind mem_addr_router mem_addr_router_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_src(req_src), .req_write(req_write), .req_smm_qual(req_smm_qual),
  .cfg_smram_en(cfg_smram_en), .cfg_hsmram_en(cfg_hsmram_en),
  .out_valid(out_valid), .out_target(out_target), .out_addr(out_addr),
  .out_intr_msg(out_intr_msg), .out_self_complete(out_self_complete),
  .out_read_zero(out_read_zero), .out_write_drop(out_write_drop)
);

// File: tb/mem_addr_router_test.sv
module mem_addr_router_test;
  localparam int AW = 32;
  localparam int DW = 16;
  localparam int NV = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_src = '0;
  logic req_write = 1'b0, req_smm_qual = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic cfg_smram_en = 1'b0, cfg_hsmram_en = 1'b0;
  logic [11:0] cfg_tom = 12'h200, cfg_ap_base = 12'hE00, cfg_ap_size = 12'h100;
  logic [11:0] cfg_mem_base = 12'hD00, cfg_mem_limit = 12'hD7F;
  logic [11:0] cfg_pmem_base = 12'hC00, cfg_pmem_limit = 12'hCFF;
  logic out_valid;
  logic [2:0] out_target;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_wdata;
  logic out_intr_msg, out_self_complete, out_read_zero, out_write_drop;

  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mem_addr_router #(.AW(AW), .DW(DW)) uut (.*);

  // addr, src, wr, qual, smram, hsm, target, exp addr, flags {intr,selfc,rzero,wdrop}
  localparam logic [76:0] VEC [NV] = '{
    {32'hFEE0_0000, 2'd1, 4'b1000, 3'd2, 32'hFEE0_0000, 4'b1100}, // R1
    {32'hFEEF_FFFF, 2'd2, 4'b1000, 3'd2, 32'hFEEF_FFFF, 4'b1100}, // R1 R2
    {32'hFEDF_FFFF, 2'd1, 4'b1000, 3'd3, 32'hFEDF_FFFF, 4'b0000}, // R10
    {32'hFEF0_0000, 2'd1, 4'b1000, 3'd3, 32'hFEF0_0000, 4'b0000}, // R10
    {32'hFEE0_0000, 2'd1, 4'b0000, 3'd3, 32'hFEE0_0000, 4'b0000}, // R2
    {32'hFEE1_2340, 2'd0, 4'b1111, 3'd3, 32'hFEE1_2340, 4'b0000}, // R2
    {32'hFEDA_0000, 2'd0, 4'b0111, 3'd0, 32'h000A_0000, 4'b0000}, // R3
    {32'hFEDB_FFFF, 2'd0, 4'b0111, 3'd0, 32'h000B_FFFF, 4'b0000}, // R3
    {32'hFEDA_0000, 2'd0, 4'b0110, 3'd3, 32'hFEDA_0000, 4'b0000}, // R4
    {32'hFEDA_0000, 2'd0, 4'b0011, 3'd3, 32'hFEDA_0000, 4'b0000}, // R4
    {32'hFEDA_0000, 2'd0, 4'b0101, 3'd3, 32'hFEDA_0000, 4'b0000}, // R4
    {32'hFED9_FFFF, 2'd0, 4'b0111, 3'd3, 32'hFED9_FFFF, 4'b0000}, // R3 edge
    {32'hFEDC_0000, 2'd0, 4'b0111, 3'd3, 32'hFEDC_0000, 4'b0000}, // R3 edge
    {32'hFEDA_8000, 2'd1, 4'b0111, 3'd0, 32'h0000_0000, 4'b0010}, // R5
    {32'hFEDB_FFFC, 2'd2, 4'b1000, 3'd4, 32'hFEDB_FFFC, 4'b0001}, // R6
    {32'hFEDA_0000, 2'd3, 4'b0000, 3'd0, 32'h0000_0000, 4'b0010}, // R5
    {32'hDFFF_FFFF, 2'd0, 4'b0000, 3'd3, 32'hDFFF_FFFF, 4'b0000}, // R7 edge
    {32'hE000_0000, 2'd0, 4'b0000, 3'd1, 32'hE000_0000, 4'b0000}, // R7
    {32'hEFFF_FFFF, 2'd2, 4'b1000, 3'd1, 32'hEFFF_FFFF, 4'b0000}, // R7
    {32'hF000_0000, 2'd0, 4'b0000, 3'd3, 32'hF000_0000, 4'b0000}, // R7 edge
    {32'hD000_0000, 2'd0, 4'b0000, 3'd1, 32'hD000_0000, 4'b0000}, // R8
    {32'hD7FF_FFFF, 2'd1, 4'b0000, 3'd1, 32'hD7FF_FFFF, 4'b0000}, // R8
    {32'hD800_0000, 2'd0, 4'b0000, 3'd3, 32'hD800_0000, 4'b0000}, // R8 edge
    {32'hC000_0000, 2'd0, 4'b1000, 3'd1, 32'hC000_0000, 4'b0000}, // R8
    {32'hCFFF_FFFF, 2'd0, 4'b0000, 3'd1, 32'hCFFF_FFFF, 4'b0000}, // R8
    {32'hBFFF_FFFF, 2'd0, 4'b0000, 3'd3, 32'hBFFF_FFFF, 4'b0000}, // R8 edge
    {32'h1FFF_FFFF, 2'd0, 4'b0000, 3'd0, 32'h1FFF_FFFF, 4'b0000}, // R10
    {32'h2000_0000, 2'd0, 4'b0000, 3'd3, 32'h2000_0000, 4'b0000}, // R10
    {32'h0000_0000, 2'd1, 4'b1000, 3'd0, 32'h0000_0000, 4'b0000}  // R10
  };

  task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [1:0] s, input logic [3:0] ctl);
    @(negedge clk);
    req_valid     = 1'b1;
    req_addr      = a;
    req_src       = s;
    req_write     = ctl[3];
    req_smm_qual  = ctl[2];
    cfg_smram_en  = ctl[1];
    cfg_hsmram_en = ctl[0];
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [2:0] t, input logic [AW-1:0] a,
                            input logic [3:0] f);
    check({tag, " target"}, AW'(out_target), AW'(t));
    check({tag, " addr"}, out_addr, a);
    check({tag, " flags"}, AW'({out_intr_msg, out_self_complete, out_read_zero, out_write_drop}), AW'(f));
    check({tag, " valid"}, AW'(out_valid), AW'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", AW'(out_valid), '0);
    check("R11 reset target", AW'(out_target), '0);
    check("R11 reset addr", out_addr, '0);
    check("R11 reset flags", AW'({out_intr_msg, out_self_complete, out_read_zero, out_write_drop}), '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][76:45], VEC[i][44:43], VEC[i][42:39]);
      expect_out($sformatf("table row %0d", i), VEC[i][38:36], VEC[i][35:4], VEC[i][3:0]);
    end

    // R1 write data carried with the interrupt message
    @(negedge clk); req_wdata = 16'hBEEF;
    issue(32'hFEE0_0040, 2'd2, 4'b1000);
    expect_out("R1 data msg", 3'd2, 32'hFEE0_0040, 4'b1100);
    check("R1 data", AW'(out_wdata), AW'(16'hBEEF));

    // R11 valid drops one cycle after request ends
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    check("R11 valid low", AW'(out_valid), '0);

    // R8 windows clipped by top of memory
    cfg_tom = 12'hD40;
    issue(32'hD200_0000, 2'd0, 4'b0000);
    expect_out("R8 clip below tom", 3'd0, 32'hD200_0000, 4'b0000);
    issue(32'hD500_0000, 2'd0, 4'b0000);
    expect_out("R8 clip above tom", 3'd1, 32'hD500_0000, 4'b0000);

    // R7 aperture based below top of memory is off
    cfg_tom = 12'hE80;
    issue(32'hE000_0000, 2'd0, 4'b0000);
    expect_out("R7 ap below tom", 3'd0, 32'hE000_0000, 4'b0000);
    issue(32'hE900_0000, 2'd0, 4'b0000);
    expect_out("R7 ap off above tom", 3'd3, 32'hE900_0000, 4'b0000);
    cfg_tom = 12'h200;

    // R7 zero size disables aperture
    cfg_ap_size = 12'h000;
    issue(32'hE000_0000, 2'd0, 4'b0000);
    expect_out("R7 ap size zero", 3'd3, 32'hE000_0000, 4'b0000);
    cfg_ap_size = 12'h100;

    // R8 limit below base disables window
    cfg_mem_limit = 12'hCFF;
    issue(32'hD000_0000, 2'd0, 4'b0000);
    expect_out("R8 window off", 3'd3, 32'hD000_0000, 4'b0000);

    // R9 priority against an overlapping window
    cfg_mem_base = 12'hFE0; cfg_mem_limit = 12'hFEF;
    issue(32'hFEDA_0000, 2'd0, 4'b0111);
    expect_out("R9 smm over window", 3'd0, 32'h000A_0000, 4'b0000);
    issue(32'hFEDA_0000, 2'd0, 4'b0110);
    expect_out("R9 R4 window when alias off", 3'd1, 32'hFEDA_0000, 4'b0000);
    issue(32'hFEE0_0000, 2'd1, 4'b1000);
    expect_out("R9 intr over window", 3'd2, 32'hFEE0_0000, 4'b1100);
    issue(32'hFEDA_0000, 2'd1, 4'b0000);
    expect_out("R9 special term over window", 3'd0, 32'h0000_0000, 4'b0010);
    cfg_mem_base = 12'hD00; cfg_mem_limit = 12'hD7F;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule